// File: doc/BRIEF.md
# Dual-Channel Temperature Limit Monitor

This block watches a stream of signed temperature results and compares each new result against two separate pairs of limits, one pair per channel. For each channel it keeps an "over" flag and an "under" flag, and it drives one alert pin whose active level is programmable. A result enters the block on a one-cycle valid strobe raised when a conversion ends. A one-cycle configuration-read strobe lets the reader acknowledge latched events.

Each channel has its own mode bit. In window mode the two limits bound an allowed band. A result outside the band latches the matching flag, and the flag holds until the configuration is read. In hysteretic mode only the over flag is used. It rises when a result climbs above the upper limit and falls only when a later result drops below the lower limit. Reads do not affect it. The limit values, mode bits and polarity bits come from registers outside the block and are held steady between changes.

Top module: `temp_limit_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, every flag is 0 and each `alert_o[c]` takes its inactive level, which is the inverse of `alert_pol_i[c]`.
- R2: In window mode (`therm_mode_i[c]`=0), a valid result whose signed two's-complement value is strictly greater than channel c's upper limit sets `flag_hi_o[c]` at the clock edge that samples the strobe.
- R3: In window mode, a valid result that is strictly less than channel c's lower limit sets `flag_lo_o[c]` at the edge that samples the strobe.
- R4: In window mode, a set flag stays set over cycles with no strobe and over in-band results. A `cfg_rd_i` pulse clears both flags of the channel at the edge that samples it.
- R5: In window mode, when a result that sets a flag arrives in the same cycle as `cfg_rd_i`, that flag ends the cycle set. A flag that the same result does not set is cleared.
- R6: In hysteretic mode (`therm_mode_i[c]`=1), a valid result above the upper limit sets `flag_hi_o[c]`. A valid result below the lower limit clears it. Any other result, or no strobe at all, leaves it unchanged.
- R7: In hysteretic mode, `flag_lo_o[c]` is 0 after every clock edge.
- R8: In hysteretic mode, `cfg_rd_i` has no effect on the channel's flags.
- R9: A result equal to a limit sets neither flag, because both comparisons are strict.
- R10: At every edge after reset, `alert_o[c]` is loaded with the OR of the channel's new flags when `alert_pol_i[c]`=1 (active high), and with the inverse of that OR when `alert_pol_i[c]`=0 (active low).
- R11: At an edge where `therm_mode_i[c]` differs from its value at the previous edge, both flags of channel c are cleared, and any result or read in that cycle is ignored for that channel.
- R12: The channels are independent. The limits, mode and polarity of one channel never change the flags or alert of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| result_i | input | TEMP_W | Signed temperature result |
| result_vld_i | input | 1 | One-cycle strobe: result_i holds a new result |
| hi_lim_i | input | NUM_CH*TEMP_W | Upper limits, channel c in bits [c*TEMP_W +: TEMP_W] |
| lo_lim_i | input | NUM_CH*TEMP_W | Lower limits, same packing |
| therm_mode_i | input | NUM_CH | Per channel: 0 window mode, 1 hysteretic mode |
| alert_pol_i | input | NUM_CH | Per channel: 0 active-low alert, 1 active-high alert |
| cfg_rd_i | input | 1 | One-cycle configuration-read strobe |
| flag_hi_o | output | NUM_CH | Over-limit flags |
| flag_lo_o | output | NUM_CH | Under-limit flags |
| alert_o | output | NUM_CH | Alert pins |

## Verification
Two pairs of events can land in the same cycle. The first pair is a clearing read and a result that sets a flag. The second is a mode change and a result strobe. The bench provokes each pair on purpose. It pulses `cfg_rd_i` in the same cycle as an out-of-band result and in the same cycle as an in-band one, and it flips a mode bit in the same cycle as a result that would otherwise set a flag. A cycle-by-cycle behavioural model judges every case on every clock: it lets a set win over a read, and it makes a mode change override everything else.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  typedef enum logic {
    MODE_WINDOW = 1'b0,
    MODE_THERM  = 1'b1
  } lim_mode_e;

  typedef struct packed {
    logic above;
    logic below;
  } cmp_res_t;
endpackage

// File: rtl/tlm_compare.sv
module tlm_compare #(
  parameter int TEMP_W = 16
) (
  input  logic [TEMP_W-1:0] sample_i,
  input  logic [TEMP_W-1:0] hi_lim_i,
  input  logic [TEMP_W-1:0] lo_lim_i,
  output tlm_pkg::cmp_res_t cmp_o
);
  always_comb begin
    cmp_o.above = $signed(sample_i) > $signed(hi_lim_i);
    cmp_o.below = $signed(sample_i) < $signed(lo_lim_i);
  end
endmodule

// File: rtl/tlm_flag_chan.sv
module tlm_flag_chan #(
  parameter int TEMP_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld_i,
  input  logic                rd_i,
  input  tlm_pkg::lim_mode_e  mode_i,
  input  tlm_pkg::cmp_res_t   cmp_i,
  output logic                hi_nxt_o,
  output logic                lo_nxt_o,
  output logic                hi_q_o,
  output logic                lo_q_o
);
  import tlm_pkg::*;

  lim_mode_e mode_q;
  logic      hi_n, lo_n;

  always_comb begin
    hi_n = hi_q_o;
    lo_n = lo_q_o;
    if (mode_i != mode_q) begin
      hi_n = 1'b0;
      lo_n = 1'b0;
    end else if (mode_i == MODE_THERM) begin
      lo_n = 1'b0;
      if (vld_i) begin
        if (cmp_i.above)      hi_n = 1'b1;
        else if (cmp_i.below) hi_n = 1'b0;
      end
    end else begin
      if (rd_i) begin
        hi_n = 1'b0;
        lo_n = 1'b0;
      end
      if (vld_i && cmp_i.above) hi_n = 1'b1;
      if (vld_i && cmp_i.below) lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_i;
    if (rst) begin
      hi_q_o <= 1'b0;
      lo_q_o <= 1'b0;
    end else begin
      hi_q_o <= hi_n;
      lo_q_o <= lo_n;
    end
  end

  assign hi_nxt_o = hi_n;
  assign lo_nxt_o = lo_n;
endmodule

// File: rtl/tlm_alert_drv.sv
module tlm_alert_drv (
  input  logic clk,
  input  logic rst,
  input  logic pol_i,
  input  logic active_i,
  output logic alert_o
);
  always_ff @(posedge clk) begin
    if (rst) alert_o <= ~pol_i;
    else     alert_o <= pol_i ? active_i : ~active_i;
  end
endmodule

// File: rtl/temp_limit_monitor.sv
module temp_limit_monitor #(
  parameter int TEMP_W = 16,
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TEMP_W-1:0]        result_i,
  input  logic                     result_vld_i,
  input  logic [NUM_CH*TEMP_W-1:0] hi_lim_i,
  input  logic [NUM_CH*TEMP_W-1:0] lo_lim_i,
  input  logic [NUM_CH-1:0]        therm_mode_i,
  input  logic [NUM_CH-1:0]        alert_pol_i,
  input  logic                     cfg_rd_i,
  output logic [NUM_CH-1:0]        flag_hi_o,
  output logic [NUM_CH-1:0]        flag_lo_o,
  output logic [NUM_CH-1:0]        alert_o
);
  import tlm_pkg::*;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int LSB = g * TEMP_W;
    cmp_res_t  cmp;
    lim_mode_e mode;
    logic      hi_nxt, lo_nxt;

    assign mode = lim_mode_e'(therm_mode_i[g]);

    tlm_compare #(.TEMP_W(TEMP_W)) u_cmp (
      .sample_i (result_i),
      .hi_lim_i (hi_lim_i[LSB +: TEMP_W]),
      .lo_lim_i (lo_lim_i[LSB +: TEMP_W]),
      .cmp_o    (cmp)
    );

    tlm_flag_chan #(.TEMP_W(TEMP_W)) u_flags (
      .clk      (clk),
      .rst      (rst),
      .vld_i    (result_vld_i),
      .rd_i     (cfg_rd_i),
      .mode_i   (mode),
      .cmp_i    (cmp),
      .hi_nxt_o (hi_nxt),
      .lo_nxt_o (lo_nxt),
      .hi_q_o   (flag_hi_o[g]),
      .lo_q_o   (flag_lo_o[g])
    );

    tlm_alert_drv u_alert (
      .clk      (clk),
      .rst      (rst),
      .pol_i    (alert_pol_i[g]),
      .active_i (hi_nxt | lo_nxt),
      .alert_o  (alert_o[g])
    );
  end
endmodule

// File: rtl/tlm_checker.sv
module tlm_checker #(
  parameter int TEMP_W = 16,
  parameter int NUM_CH = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [TEMP_W-1:0]        result_i,
  input logic                     result_vld_i,
  input logic [NUM_CH*TEMP_W-1:0] hi_lim_i,
  input logic [NUM_CH*TEMP_W-1:0] lo_lim_i,
  input logic [NUM_CH-1:0]        therm_mode_i,
  input logic [NUM_CH-1:0]        alert_pol_i,
  input logic                     cfg_rd_i,
  input logic [NUM_CH-1:0]        flag_hi_o,
  input logic [NUM_CH-1:0]        flag_lo_o,
  input logic [NUM_CH-1:0]        alert_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic gt, lt, eq_hi;
    assign gt    = $signed(result_i) > $signed(hi_lim_i[g*TEMP_W +: TEMP_W]);
    assign lt    = $signed(result_i) < $signed(lo_lim_i[g*TEMP_W +: TEMP_W]);
    assign eq_hi = result_i == hi_lim_i[g*TEMP_W +: TEMP_W];

    assert_win_hi_set_R2: assert property (@(posedge clk) disable iff (rst)
      (!therm_mode_i[g] && $stable(therm_mode_i[g]) && result_vld_i && gt) |=> flag_hi_o[g]);

    assert_win_lo_set_R3: assert property (@(posedge clk) disable iff (rst)
      (!therm_mode_i[g] && $stable(therm_mode_i[g]) && result_vld_i && lt) |=> flag_lo_o[g]);

    assert_win_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!therm_mode_i[g] && $stable(therm_mode_i[g]) && !cfg_rd_i && flag_hi_o[g]) |=> flag_hi_o[g]);

    assert_win_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (!therm_mode_i[g] && $stable(therm_mode_i[g]) && cfg_rd_i && !(result_vld_i && gt)) |=> !flag_hi_o[g]);

    assert_therm_lo_zero_R7: assert property (@(posedge clk) disable iff (rst)
      therm_mode_i[g] |=> !flag_lo_o[g]);

    assert_therm_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      (therm_mode_i[g] && $stable(therm_mode_i[g]) && !result_vld_i) |=> $stable(flag_hi_o[g]));

    assert_equal_no_set_R9: assert property (@(posedge clk) disable iff (rst)
      ($stable(therm_mode_i[g]) && result_vld_i && eq_hi && !flag_hi_o[g]) |=> !flag_hi_o[g]);

    assert_alert_level_R10: assert property (@(posedge clk) disable iff (rst)
      alert_o[g] == ((flag_hi_o[g] | flag_lo_o[g]) ~^ $past(alert_pol_i[g])));

    assert_mode_clear_R11: assert property (@(posedge clk) disable iff (rst)
      !$stable(therm_mode_i[g]) |=> (!flag_hi_o[g] && !flag_lo_o[g]));
  end
endmodule

bind temp_limit_monitor tlm_checker #(.TEMP_W(TEMP_W), .NUM_CH(NUM_CH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .result_i     (result_i),
  .result_vld_i (result_vld_i),
  .hi_lim_i     (hi_lim_i),
  .lo_lim_i     (lo_lim_i),
  .therm_mode_i (therm_mode_i),
  .alert_pol_i  (alert_pol_i),
  .cfg_rd_i     (cfg_rd_i),
  .flag_hi_o    (flag_hi_o),
  .flag_lo_o    (flag_lo_o),
  .alert_o      (alert_o)
);

// File: tb/temp_limit_monitor_tb_top.sv
`timescale 1ns/100ps
module temp_limit_monitor_tb_top;
  localparam int TW = 16;
  localparam int NC = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [TW-1:0]    result_i = '0;
  logic             result_vld_i = 1'b0;
  logic [NC*TW-1:0] hi_lim_i = '0;
  logic [NC*TW-1:0] lo_lim_i = '0;
  logic [NC-1:0]    therm_mode_i = '0;
  logic [NC-1:0]    alert_pol_i = 2'b01;
  logic             cfg_rd_i = 1'b0;
  logic [NC-1:0]    flag_hi_o, flag_lo_o, alert_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural model state
  bit m_hi[NC];
  bit m_lo[NC];
  bit m_al[NC];
  bit m_mode[NC];

  always #2 clk = ~clk;

  temp_limit_monitor #(.TEMP_W(TW), .NUM_CH(NC)) dut_i (
    .clk(clk), .rst(rst), .result_i(result_i), .result_vld_i(result_vld_i),
    .hi_lim_i(hi_lim_i), .lo_lim_i(lo_lim_i), .therm_mode_i(therm_mode_i),
    .alert_pol_i(alert_pol_i), .cfg_rd_i(cfg_rd_i),
    .flag_hi_o(flag_hi_o), .flag_lo_o(flag_lo_o), .alert_o(alert_o)
  );

  function automatic int lim_of(input logic [NC*TW-1:0] v, input int c);
    logic signed [TW-1:0] s;
    s = v[c*TW +: TW];
    return int'(s);
  endfunction

  always @(posedge clk) begin
    int r;
    r = int'($signed(result_i));
    for (int c = 0; c < NC; c++) begin
      if (rst) begin
        m_hi[c] = 1'b0;
        m_lo[c] = 1'b0;
        m_al[c] = !alert_pol_i[c];
      end else begin
        if (m_mode[c] != therm_mode_i[c]) begin
          m_hi[c] = 1'b0;
          m_lo[c] = 1'b0;
        end else if (therm_mode_i[c]) begin
          m_lo[c] = 1'b0;
          if (result_vld_i && r > lim_of(hi_lim_i, c)) m_hi[c] = 1'b1;
          else if (result_vld_i && r < lim_of(lo_lim_i, c)) m_hi[c] = 1'b0;
        end else begin
          if (cfg_rd_i) begin
            m_hi[c] = 1'b0;
            m_lo[c] = 1'b0;
          end
          if (result_vld_i && r > lim_of(hi_lim_i, c)) m_hi[c] = 1'b1;
          if (result_vld_i && r < lim_of(lo_lim_i, c)) m_lo[c] = 1'b1;
        end
        m_al[c] = alert_pol_i[c] ? (m_hi[c] | m_lo[c]) : !(m_hi[c] | m_lo[c]);
      end
      m_mode[c] = therm_mode_i[c];
    end
  end

  task automatic check1(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model (R12: both channels each cycle)
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < NC; c++) begin
        check1(cur_req, $sformatf("ch%0d flag_hi", c), int'(flag_hi_o[c]), int'(m_hi[c]));
        check1(cur_req, $sformatf("ch%0d flag_lo", c), int'(flag_lo_o[c]), int'(m_lo[c]));
        check1(cur_req, $sformatf("ch%0d alert", c), int'(alert_o[c]), int'(m_al[c]));
      end
    end
  end

  task automatic step(input int r, input bit v, input bit rd);
    @(negedge clk);
    result_i = TW'(r);
    result_vld_i = v;
    cfg_rd_i = rd;
  endtask

  // directed check of hand-computed values right after the following edge
  task automatic expect_ch(input string req, input int c, input bit eh, input bit el, input bit ea);
    @(posedge clk);
    #1;
    check1(req, $sformatf("directed ch%0d flag_hi", c), int'(flag_hi_o[c]), int'(eh));
    check1(req, $sformatf("directed ch%0d flag_lo", c), int'(flag_lo_o[c]), int'(el));
    check1(req, $sformatf("directed ch%0d alert", c), int'(alert_o[c]), int'(ea));
  endtask

  task automatic set_lim(input int c, input int hi, input int lo);
    hi_lim_i[c*TW +: TW] = TW'(hi);
    lo_lim_i[c*TW +: TW] = TW'(lo);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_lim(0, 100, -50);
    set_lim(1, 200, 0);
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state, ch0 active high -> 0, ch1 active low -> 1
    check1("R1", "reset flag_hi", int'(flag_hi_o), 0);
    check1("R1", "reset flag_lo", int'(flag_lo_o), 0);
    check1("R1", "reset alert", int'(alert_o), 2);
    @(negedge clk);
    rst = 1'b0;

    cur_req = "R2";
    step(101, 1, 0);  expect_ch("R2", 0, 1, 0, 1);
    cur_req = "R4";
    step(0, 0, 0);    expect_ch("R4", 0, 1, 0, 1);
    step(0, 0, 1);    expect_ch("R4", 0, 0, 0, 0);
    cur_req = "R9";
    step(100, 1, 0);  expect_ch("R9", 0, 0, 0, 0);
    step(-50, 1, 0);  expect_ch("R9", 0, 0, 0, 0);
    cur_req = "R3";
    step(0, 0, 0);    expect_ch("R3", 1, 0, 1, 0);   // -50 < 0 on ch1, active low
    step(-51, 1, 0);  expect_ch("R3", 0, 0, 1, 1);
    cur_req = "R5";
    step(150, 1, 1);  expect_ch("R5", 0, 1, 0, 1);
    step(0, 0, 0);    expect_ch("R5", 1, 0, 0, 1);
    cur_req = "R11";
    @(negedge clk); therm_mode_i = 2'b10; result_i = TW'(250); result_vld_i = 1'b1; cfg_rd_i = 1'b0;
    expect_ch("R11", 1, 0, 0, 1);
    cur_req = "R6";
    step(250, 1, 0);  expect_ch("R6", 1, 1, 0, 0);
    cur_req = "R8";
    step(100, 1, 1);  expect_ch("R8", 1, 1, 0, 0);
    expect_ch("R12", 0, 0, 0, 0);
    cur_req = "R7";
    step(-5, 1, 0);   expect_ch("R7", 1, 0, 0, 1);
    cur_req = "R10";
    @(negedge clk); alert_pol_i = 2'b10; result_vld_i = 1'b0; cfg_rd_i = 1'b0;
    expect_ch("R10", 0, 0, 0, 1);
    cur_req = "R11";
    step(300, 1, 0);  expect_ch("R6", 1, 1, 0, 1);
    @(negedge clk); therm_mode_i = 2'b00; result_vld_i = 1'b0;
    expect_ch("R11", 1, 0, 0, 0);

    cur_req = "R12";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      result_i = TW'(int'($urandom_range(0, 500)) - 250);
      result_vld_i = ($urandom_range(0, 3) != 0);
      cfg_rd_i = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 40) == 0) therm_mode_i = therm_mode_i ^ 2'(1 << $urandom_range(0, 1));
      if ($urandom_range(0, 50) == 0) alert_pol_i = alert_pol_i ^ 2'(1 << $urandom_range(0, 1));
      if (i == 300) begin
        set_lim(0, 10, 10);
        set_lim(1, -20, -100);
      end
    end
    @(negedge clk);
    result_vld_i = 1'b0;
    cfg_rd_i = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule